// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the entry phase of an interrupt for a small 8-bit processor core with a 16-bit program counter and a 16-bit stack pointer. The core presents its interrupt requests and a snapshot of its state: the enable flip-flops, the interrupt mode, the vector page register, PC, SP, the 7-bit refresh counter, the halted flag and the running cycle count. The block decides whether an entry happens and which kind it is. It then pushes the return address through a byte-wide synchronous memory port and, in table mode, fetches the target address from memory. When it finishes, it presents the values the core should load.

A non-maskable request is detected on its rising edge and always wins. A maskable request is a level, and it is accepted only while the first enable flip-flop is set. The target is one of three things: a fixed restart address, the non-maskable restart address, or a 16-bit pointer read from a table page selected by the vector page register. If the core was halted, the return address points past the halt opcode. A one-cycle `done_o` pulse marks the cycle in which the new PC and the other results are valid. An illegal mode value (3) raises an error pulse instead of starting an entry.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable request (`irq_req_i`=1) starts an entry only when `iff1_i`=1 and no entry is in progress. If `iff1_i`=0, the request causes no memory write, no read and no `done_o`, and `iff1_o` keeps following `iff1_i`.
- R2: If `halted_i`=1 when an entry is accepted, the pushed return address is PC+1 (mod 65536), and `halted_o` is 0 from acceptance through the `done_o` cycle.
- R3: During `done_o`, `cycle_o` equals `cycle_i`+7 and `rfsh_o` equals (`rfsh_i`+1) mod 128, using the input values sampled at acceptance.
- R4: `iff1_o` and `iff2_o` are both 0 from acceptance through the `done_o` cycle, for both kinds of entry. Outside an entry they follow `iff1_i` and `iff2_i`.
- R5: The first memory write comes one cycle after the accepting clock edge, at address SP-1 with data return[15:8]. The second write follows in the next cycle, at address SP-2 with data return[7:0]. `new_sp_o` equals SP-2 (mod 65536). No cycle has both a write and a read.
- R6: In mode 0 or mode 1 (`irq_mode_i` = 2'd0 or 2'd1), a maskable entry makes `new_pc_o` 16'h0038, performs no reads, and asserts `done_o` three cycles after the accepting edge.
- R7: In mode 2 (`irq_mode_i` = 2'd2), after the pushes the block reads address {`ivec_page_i`, 8'hFF} and then that address plus one (16-bit wrap). Read data arrives one cycle after the read. The first byte becomes `new_pc_o`[7:0] and the second becomes `new_pc_o`[15:8]. `done_o` comes six cycles after the accepting edge.
- R8: A rising edge on `nmi_req_i` starts an entry regardless of `iff1_i` and of the mode. This entry makes `new_pc_o` 16'h0066 and performs no reads.
- R9: A non-maskable edge wins over a maskable request in the same cycle, and that maskable request is not taken. An edge that arrives during an entry is remembered and served after it. A level held high produces exactly one entry.
- R10: `done_o` is high for exactly one cycle per entry.
- R11: A maskable request with `iff1_i`=1 and `irq_mode_i`=2'd3 (and no non-maskable edge) pulses `mode_err_o` in the same cycle and starts no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 1 | Maskable request, level |
| nmi_req_i | input | 1 | Non-maskable request, edge detected |
| iff1_i | input | 1 | First enable flip-flop from the core |
| iff2_i | input | 1 | Second enable flip-flop from the core |
| irq_mode_i | input | 2 | Interrupt mode 0..3 |
| ivec_page_i | input | 8 | Vector page register |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| rfsh_i | input | 7 | Refresh counter |
| halted_i | input | 1 | Core is halted |
| cycle_i | input | 32 | Running cycle count |
| mem_addr_o | output | 16 | Memory address |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the read |
| done_o | output | 1 | Results valid, one-cycle pulse |
| new_pc_o | output | 16 | PC to load |
| new_sp_o | output | 16 | SP to load |
| iff1_o | output | 1 | First enable flip-flop to load |
| iff2_o | output | 1 | Second enable flip-flop to load |
| halted_o | output | 1 | Halted flag to load |
| rfsh_o | output | 7 | Refresh counter to load |
| cycle_o | output | 32 | Cycle count to load |
| mode_err_o | output | 1 | Illegal mode on a maskable request |

## Verification
The hardest situation to reach from the ports is a non-maskable edge that lands while a maskable entry is still pushing. The edge must be held as pending and produce a second, separate entry after the first finishes. The bench reaches it by dropping the maskable request right after acceptance and pulsing the non-maskable input one cycle later, then counting two `done_o` pulses. The same sweep also covers a non-maskable level held high for many cycles, simultaneous requests in every mode, a stack pointer of 1 (so the low-byte push wraps to 16'hFFFF), and a vector page of 8'hFF (so the second table read wraps to 16'h0000).

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned RFSH_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_VEC_WAIT,
    ST_FINISH
  } entry_state_t;

  typedef enum logic [1:0] {
    MD_FIXED_A = 2'd0,
    MD_FIXED_B = 2'd1,
    MD_TABLE   = 2'd2,
    MD_BAD     = 2'd3
  } irq_mode_t;

endpackage

// File: rtl/irq_req_arb.sv
module irq_req_arb
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_i,
  input  logic       mask_i,
  input  logic       iff1_i,
  input  logic [1:0] mode_i,
  input  logic       busy_i,
  output logic       take_nmi_o,
  output logic       take_mask_o,
  output logic       mode_err_o,
  output logic       nmi_edge_o,
  output logic       nmi_pend_o
);

  logic nmi_q;
  logic pend_q;
  logic mask_ok;

  // Rising edge of the non-maskable line.
  assign nmi_edge_o = nmi_i & ~nmi_q;
  assign nmi_pend_o = pend_q;

  // A pending or fresh edge is served as soon as the sequencer is idle.
  assign take_nmi_o = ~busy_i & (pend_q | nmi_edge_o);

  // A maskable request is qualified by the enable flip-flop and loses to a non-maskable one.
  assign mask_ok     = ~busy_i & ~take_nmi_o & mask_i & iff1_i;
  assign take_mask_o = mask_ok & (irq_mode_t'(mode_i) != MD_BAD);
  assign mode_err_o  = mask_ok & (irq_mode_t'(mode_i) == MD_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      if (take_nmi_o) begin
        pend_q <= 1'b0;
      end else if (nmi_edge_o) begin
        pend_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
#(
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned DW      = DATA_W,
  parameter int unsigned RW      = RFSH_W,
  parameter int unsigned CW      = 32,
  parameter int unsigned ENTRY_T = 7,
  parameter logic [AW-1:0] FIX_VEC = 'h0038,
  parameter logic [AW-1:0] NMI_VEC = 'h0066
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_nmi_i,
  input  logic          start_mask_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] page_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  input  logic [RW-1:0] rfsh_i,
  input  logic          halted_i,
  input  logic [CW-1:0] cycle_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_wr_o,
  output logic          mem_rd_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [AW-1:0] new_pc_o,
  output logic [AW-1:0] new_sp_o,
  output logic [RW-1:0] rfsh_o,
  output logic [CW-1:0] cycle_o,
  output logic          push_hi_ev_o,
  output logic          push_lo_ev_o,
  output logic          vec_rd_ev_o
);

  localparam int unsigned HW = AW - DW;

  // Arithmetic kept in functions so that each rule sits in one place.
  function automatic logic [AW-1:0] resume_pc(input logic [AW-1:0] pc, input logic halted);
    return pc + AW'(halted);
  endfunction

  function automatic logic [AW-1:0] stack_slot(input logic [AW-1:0] sp, input int unsigned depth);
    return sp - AW'(depth);
  endfunction

  function automatic logic [AW-1:0] table_base(input logic [DW-1:0] page);
    return AW'({page, {DW{1'b1}}});
  endfunction

  function automatic logic [RW-1:0] rfsh_step(input logic [RW-1:0] r);
    return r + RW'(1);
  endfunction

  entry_state_t  state_q;
  logic [AW-1:0] ret_pc_q;
  logic [AW-1:0] sp_q;
  logic [AW-1:0] new_sp_q;
  logic [AW-1:0] target_q;
  logic [DW-1:0] page_q;
  logic          use_table_q;
  logic [RW-1:0] rfsh_q;
  logic [CW-1:0] cycle_q;
  logic          start;

  assign start = start_nmi_i | start_mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ret_pc_q    <= '0;
      sp_q        <= '0;
      new_sp_q    <= '0;
      target_q    <= '0;
      page_q      <= '0;
      use_table_q <= 1'b0;
      rfsh_q      <= '0;
      cycle_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            ret_pc_q    <= resume_pc(pc_i, halted_i);
            sp_q        <= sp_i;
            new_sp_q    <= stack_slot(sp_i, 2);
            page_q      <= page_i;
            use_table_q <= start_mask_i & (irq_mode_t'(mode_i) == MD_TABLE);
            target_q    <= start_nmi_i ? NMI_VEC : FIX_VEC;
            rfsh_q      <= rfsh_step(rfsh_i);
            cycle_q     <= cycle_i + CW'(ENTRY_T);
            state_q     <= ST_PUSH_HI;
          end
        end
        ST_PUSH_HI:  state_q <= ST_PUSH_LO;
        ST_PUSH_LO:  state_q <= use_table_q ? ST_VEC_LO : ST_FINISH;
        ST_VEC_LO:   state_q <= ST_VEC_HI;
        ST_VEC_HI: begin
          target_q[DW-1:0] <= mem_rdata_i;
          state_q          <= ST_VEC_WAIT;
        end
        ST_VEC_WAIT: begin
          target_q[AW-1:DW] <= HW'(mem_rdata_i);
          state_q           <= ST_FINISH;
        end
        ST_FINISH:   state_q <= ST_IDLE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  assign push_hi_ev_o = (state_q == ST_PUSH_HI);
  assign push_lo_ev_o = (state_q == ST_PUSH_LO);
  assign vec_rd_ev_o  = (state_q == ST_VEC_LO) | (state_q == ST_VEC_HI);

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_PUSH_HI: begin
        mem_addr_o  = stack_slot(sp_q, 1);
        mem_wdata_o = DW'(ret_pc_q[AW-1:DW]);
      end
      ST_PUSH_LO: begin
        mem_addr_o  = stack_slot(sp_q, 2);
        mem_wdata_o = ret_pc_q[DW-1:0];
      end
      ST_VEC_LO:  mem_addr_o = table_base(page_q);
      ST_VEC_HI:  mem_addr_o = table_base(page_q) + AW'(1);
      default: ;
    endcase
  end

  assign mem_wr_o = push_hi_ev_o | push_lo_ev_o;
  assign mem_rd_o = vec_rd_ev_o;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FINISH);
  assign new_pc_o = target_q;
  assign new_sp_o = new_sp_q;
  assign rfsh_o   = rfsh_q;
  assign cycle_o  = cycle_q;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned DW      = DATA_W,
  parameter int unsigned RW      = RFSH_W,
  parameter int unsigned CW      = 32,
  parameter int unsigned ENTRY_T = 7,
  parameter logic [AW-1:0] FIX_VEC = 'h0038,
  parameter logic [AW-1:0] NMI_VEC = 'h0066
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req_i,
  input  logic          nmi_req_i,
  input  logic          iff1_i,
  input  logic          iff2_i,
  input  logic [1:0]    irq_mode_i,
  input  logic [DW-1:0] ivec_page_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  input  logic [RW-1:0] rfsh_i,
  input  logic          halted_i,
  input  logic [CW-1:0] cycle_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_wr_o,
  output logic          mem_rd_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [AW-1:0] new_pc_o,
  output logic [AW-1:0] new_sp_o,
  output logic          iff1_o,
  output logic          iff2_o,
  output logic          halted_o,
  output logic [RW-1:0] rfsh_o,
  output logic [CW-1:0] cycle_o,
  output logic          mode_err_o
);

  // Internal events, named so the checker can observe them.
  logic start_nmi;
  logic start_mask;
  logic nmi_edge;
  logic nmi_pend;
  logic busy;
  logic push_hi_ev;
  logic push_lo_ev;
  logic vec_rd_ev;

  irq_req_arb u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .nmi_i       (nmi_req_i),
    .mask_i      (irq_req_i),
    .iff1_i      (iff1_i),
    .mode_i      (irq_mode_i),
    .busy_i      (busy),
    .take_nmi_o  (start_nmi),
    .take_mask_o (start_mask),
    .mode_err_o  (mode_err_o),
    .nmi_edge_o  (nmi_edge),
    .nmi_pend_o  (nmi_pend)
  );

  irq_entry_fsm #(
    .AW      (AW),
    .DW      (DW),
    .RW      (RW),
    .CW      (CW),
    .ENTRY_T (ENTRY_T),
    .FIX_VEC (FIX_VEC),
    .NMI_VEC (NMI_VEC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_nmi_i  (start_nmi),
    .start_mask_i (start_mask),
    .mode_i       (irq_mode_i),
    .page_i       (ivec_page_i),
    .pc_i         (pc_i),
    .sp_i         (sp_i),
    .rfsh_i       (rfsh_i),
    .halted_i     (halted_i),
    .cycle_i      (cycle_i),
    .mem_rdata_i  (mem_rdata_i),
    .busy_o       (busy),
    .done_o       (done_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wr_o     (mem_wr_o),
    .mem_rd_o     (mem_rd_o),
    .mem_wdata_o  (mem_wdata_o),
    .new_pc_o     (new_pc_o),
    .new_sp_o     (new_sp_o),
    .rfsh_o       (rfsh_o),
    .cycle_o      (cycle_o),
    .push_hi_ev_o (push_hi_ev),
    .push_lo_ev_o (push_lo_ev),
    .vec_rd_ev_o  (vec_rd_ev)
  );

  // While an entry runs, both enables and the halted flag read as cleared.
  assign iff1_o   = busy ? 1'b0 : iff1_i;
  assign iff2_o   = busy ? 1'b0 : iff2_i;
  assign halted_o = busy ? 1'b0 : halted_i;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned AW = 16
)(
  input logic          clk,
  input logic          rst_n,
  input logic          irq_req_i,
  input logic          iff1_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_wr_o,
  input logic          mem_rd_o,
  input logic          done_o,
  input logic          iff1_o,
  input logic          iff2_o,
  input logic          halted_o,
  input logic          mode_err_o,
  input logic          start_nmi,
  input logic          start_mask,
  input logic          push_hi_ev,
  input logic          push_lo_ev,
  input logic          nmi_edge,
  input logic          nmi_pend,
  input logic          busy
);

  // R1: a maskable start needs the request and the enable.
  p_accept_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_mask |-> (irq_req_i && iff1_i));

  // R2: halted flag reads cleared when results are valid.
  p_halt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !halted_o);

  // R4: both enables cleared when results are valid.
  p_iff_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!iff1_o && !iff2_o));

  // R5: the low-byte push follows the high-byte push one address lower.
  p_push_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_hi_ev |=> (push_lo_ev && mem_wr_o && mem_addr_o == $past(mem_addr_o) - AW'(1)));

  // R5: never a read and a write together.
  p_rw_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_o && mem_rd_o));

  // R7: the second table read is one address above the first.
  p_vec_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !$past(mem_rd_o)) |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o) + AW'(1)));

  // R9: an idle-time edge or pending event starts a non-maskable entry, never a maskable one.
  p_nmi_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((nmi_edge || nmi_pend) && !busy) |-> (start_nmi && !start_mask));

  // R10: results valid for one cycle only.
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11: an illegal mode starts nothing.
  p_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |=> !busy);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req_i  (irq_req_i),
  .iff1_i     (iff1_i),
  .mem_addr_o (mem_addr_o),
  .mem_wr_o   (mem_wr_o),
  .mem_rd_o   (mem_rd_o),
  .done_o     (done_o),
  .iff1_o     (iff1_o),
  .iff2_o     (iff2_o),
  .halted_o   (halted_o),
  .mode_err_o (mode_err_o),
  .start_nmi  (start_nmi),
  .start_mask (start_mask),
  .push_hi_ev (push_hi_ev),
  .push_lo_ev (push_lo_ev),
  .nmi_edge   (nmi_edge),
  .nmi_pend   (nmi_pend),
  .busy       (busy)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic        nmi_req = 1'b0;
  logic        iff1 = 1'b0;
  logic        iff2 = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  page = 8'h00;
  logic [15:0] pc = 16'h0000;
  logic [15:0] sp = 16'h0000;
  logic [6:0]  rfsh = 7'h00;
  logic        halted = 1'b0;
  logic [31:0] cycle = 32'h0;
  logic [15:0] mem_addr;
  logic        mem_wr;
  logic        mem_rd;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        done;
  logic [15:0] new_pc;
  logic [15:0] new_sp;
  logic        iff1_o;
  logic        iff2_o;
  logic        halted_o;
  logic [6:0]  rfsh_o;
  logic [31:0] cycle_o;
  logic        mode_err;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req_i   (irq_req),
    .nmi_req_i   (nmi_req),
    .iff1_i      (iff1),
    .iff2_i      (iff2),
    .irq_mode_i  (mode),
    .ivec_page_i (page),
    .pc_i        (pc),
    .sp_i        (sp),
    .rfsh_i      (rfsh),
    .halted_i    (halted),
    .cycle_i     (cycle),
    .mem_addr_o  (mem_addr),
    .mem_wr_o    (mem_wr),
    .mem_rd_o    (mem_rd),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .done_o      (done),
    .new_pc_o    (new_pc),
    .new_sp_o    (new_sp),
    .iff1_o      (iff1_o),
    .iff2_o      (iff2_o),
    .halted_o    (halted_o),
    .rfsh_o      (rfsh_o),
    .cycle_o     (cycle_o),
    .mode_err_o  (mode_err)
  );

  // Memory contents are a function of the address; data returns one cycle after the read.
  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return (a[15:8] * 8'd3) ^ a[7:0] ^ 8'hA5;
  endfunction

  always @(posedge clk) mem_rdata <= mem_rd ? mem_val(mem_addr) : 8'h00;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // kind: 0 maskable only, 1 non-maskable only, 2 both in the same cycle
  task automatic run_case(input int kind, input logic [1:0] md, input logic ie, input logic hl,
                          input logic [7:0] pg, input logic [15:0] p, input logic [15:0] s,
                          input logic [6:0] rf, input logic [31:0] cy);
    bit taken, is_nmi, tbl;
    int lat, nwr, nrd, ndone, done_at;
    logic [15:0] wa [2];
    logic [7:0]  wd [2];
    logic [15:0] ra [2];
    logic [15:0] ret, base, exp_pc;
    logic [15:0] got_pc, got_sp;
    logic [6:0]  got_rf;
    logic [31:0] got_cy;
    logic        got_f1, got_f2, got_h;
    taken  = (kind != 0) || (ie && md != 2'd3);
    is_nmi = (kind != 0);
    tbl    = !is_nmi && md == 2'd2;
    lat    = tbl ? 6 : 3;
    ret    = p + 16'(hl);
    base   = {pg, 8'hFF};
    exp_pc = is_nmi ? 16'h0066 : (tbl ? {mem_val(base + 16'd1), mem_val(base)} : 16'h0038);
    nwr = 0; nrd = 0; ndone = 0; done_at = 0;
    got_pc = '0; got_sp = '0; got_rf = '0; got_cy = '0; got_f1 = 1'b1; got_f2 = 1'b1; got_h = 1'b1;
    mode = md; iff1 = ie; iff2 = ~ie; halted = hl; page = pg; pc = p; sp = s; rfsh = rf; cycle = cy;
    irq_req = (kind != 1);
    nmi_req = (kind != 0);
    #1;
    chk(mode_err == (kind == 0 && ie && md == 2'd3), "R11 mode_err", 32'(mode_err),
        32'(kind == 0 && ie && md == 2'd3));
    for (int c = 1; c <= 9; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 1) begin
        irq_req = 1'b0;
        nmi_req = 1'b0;
      end
      if (mem_wr) begin
        if (nwr < 2) begin wa[nwr] = mem_addr; wd[nwr] = mem_wdata; end
        nwr++;
      end
      if (mem_rd) begin
        if (nrd < 2) ra[nrd] = mem_addr;
        nrd++;
      end
      if (done) begin
        ndone++;
        done_at = c;
        got_pc = new_pc; got_sp = new_sp; got_rf = rfsh_o; got_cy = cycle_o;
        got_f1 = iff1_o; got_f2 = iff2_o; got_h = halted_o;
      end
    end
    if (!taken) begin
      chk(nwr == 0, "R1/R11 no write", 32'(nwr), 0);
      chk(nrd == 0, "R1/R11 no read", 32'(nrd), 0);
      chk(ndone == 0, "R1/R11 no done", 32'(ndone), 0);
      chk(iff1_o == ie, "R4 iff1 follows input", 32'(iff1_o), 32'(ie));
    end else begin
      chk(ndone == 1, "R10 one done", 32'(ndone), 1);
      chk(done_at == lat, "R6/R7 done latency", 32'(done_at), 32'(lat));
      chk(nwr == 2, "R5 write count", 32'(nwr), 2);
      if (nwr == 2) begin
        chk(wa[0] == s - 16'd1, "R5 high push addr", 32'(wa[0]), 32'(s - 16'd1));
        chk(wd[0] == ret[15:8], "R5/R2 high push data", 32'(wd[0]), 32'(ret[15:8]));
        chk(wa[1] == s - 16'd2, "R5 low push addr", 32'(wa[1]), 32'(s - 16'd2));
        chk(wd[1] == ret[7:0], "R5/R2 low push data", 32'(wd[1]), 32'(ret[7:0]));
      end
      chk(nrd == (tbl ? 2 : 0), "R6/R7/R8 read count", 32'(nrd), tbl ? 2 : 0);
      if (tbl && nrd == 2) begin
        chk(ra[0] == base, "R7 first table addr", 32'(ra[0]), 32'(base));
        chk(ra[1] == base + 16'd1, "R7 second table addr", 32'(ra[1]), 32'(base + 16'd1));
      end
      chk(got_pc == exp_pc, is_nmi ? "R8/R9 new pc" : "R6/R7 new pc", 32'(got_pc), 32'(exp_pc));
      chk(got_sp == s - 16'd2, "R5 new sp", 32'(got_sp), 32'(s - 16'd2));
      chk(got_rf == rf + 7'd1, "R3 refresh", 32'(got_rf), 32'(rf + 7'd1));
      chk(got_cy == cy + 32'd7, "R3 cycle", got_cy, cy + 32'd7);
      chk(!got_f1 && !got_f2, "R4 enables cleared", {30'd0, got_f1, got_f2}, 0);
      chk(!got_h, "R2 halted cleared", 32'(got_h), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int nd;
    repeat (3) @(negedge clk);
    chk(!done && !mem_wr && !mem_rd, "R10 reset idle", {29'd0, done, mem_wr, mem_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mode_err, "R1 idle after reset", {30'd0, done, mode_err}, 0);

    // Sweep kind x mode x enable x halted.
    for (int k = 0; k < 3; k++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          for (int h = 0; h < 2; h++)
            run_case(k, 2'(m), 1'(e), 1'(h), 8'(8'h21 + 8'(m * 37 + k * 5 + e)),
                     16'(16'h1234 + 16'(m * 4099 + k * 77 + h)), 16'(16'hC000 + 16'(k * 256 + m * 16 + e)),
                     7'(m * 30 + k * 9 + h), 32'(1000 * m + 10 * k + e));

    // Boundary cases.
    run_case(0, 2'd1, 1'b1, 1'b1, 8'h00, 16'hFFFF, 16'h0001, 7'h7F, 32'hFFFF_FFF0); // R2 wrap, R5 sp wrap, R3
    run_case(0, 2'd2, 1'b1, 1'b0, 8'hFF, 16'h8001, 16'h0000, 7'h7F, 32'h0);          // R7 table wrap
    run_case(1, 2'd3, 1'b0, 1'b1, 8'h00, 16'hFFFF, 16'h0002, 7'h40, 32'h5);          // R8 bad mode, disabled

    // R9: level held high gives one entry.
    nmi_req = 1'b1; irq_req = 1'b0;
    nd = 0;
    for (int c = 0; c < 15; c++) begin
      @(posedge clk); @(negedge clk);
      if (done) nd++;
    end
    chk(nd == 1, "R9 held level single entry", 32'(nd), 1);
    nmi_req = 1'b0;
    repeat (3) @(negedge clk);

    // R9: edge during a maskable entry is served after it.
    mode = 2'd0; iff1 = 1'b1; irq_req = 1'b1;
    nd = 0;
    for (int c = 1; c <= 15; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == 1) begin irq_req = 1'b0; nmi_req = 1'b1; end
      if (c == 2) nmi_req = 1'b0;
      if (done) begin
        nd++;
        if (nd == 1) chk(new_pc == 16'h0038, "R9 first entry maskable", 32'(new_pc), 32'h38);
        if (nd == 2) chk(new_pc == 16'h0066, "R9 pending served", 32'(new_pc), 32'h66);
      end
    end
    chk(nd == 2, "R9 pending edge count", 32'(nd), 2);

    summary();
  end

endmodule